// File: doc/BRIEF.md
# Banked GPIO Port with Per-Pin Drive Mode

This block is one bank of up to eight general-purpose pins. Software reaches it through a byte-wide register port, the kind a configuration-port decoder produces: an address, a write strobe, write data, and read data that follows the address with no clock delay. The bank uses four consecutive register indexes that start at a base set by a parameter. Each pin has a direction bit, an output latch bit and a drive-mode bit. The bank also has a read-only view of the pin levels.

Each pin leaves the block as two signals, an output enable and an output value, so the pad cell can be a plain tri-state buffer. A pin in push-pull mode drives its latch value. A pin in open-drain mode only pulls low, and it lets go of the line when its latch is 1. Pad levels enter through a synchroniser of two or more flops.

The number of implemented pins is a parameter from 4 to 8. The missing upper bits cannot be written and always read as zero. For glitch-free start-up, software writes the latch before it turns the pin into an output.

Top module: `gpio_bank`

## Requirements
- R1: While reset is active and after it is released, the direction, output-latch and drive-mode registers hold 0, every pad output enable is 0, and every pin is an open-drain input.
- R2: The register index is decoded as follows: BASE+0 is direction, BASE+1 is output latch, BASE+2 is pin level and BASE+3 is drive mode. BASE must be a multiple of 4. A write to any other index changes nothing, and a read of any other index returns 0.
- R3: A direction bit of 1 makes the pin an output. A direction bit of 0 makes it an input, and its pad output enable is 0 whatever the latch and mode bits hold.
- R4: For an output pin with drive-mode bit 1 (push-pull), the output enable is 1 and the pad value equals the latch bit.
- R5: For an output pin with drive-mode bit 0 (open-drain), the output enable equals the inverse of the latch bit and the pad value is 0, so the pin never drives high.
- R6: A read of the pin-level register returns, for each implemented bit, the latch bit if that pin is an output and the synchronised pad level if it is an input. A change on a pad first shows in this read after the second rising clock edge.
- R7: The pin-level register is read-only. A write to it leaves direction, latch and mode unchanged.
- R8: Bits at or above PIN_COUNT ignore writes, read as 0 in all four registers, and never assert a pad output enable.
- R9: A write takes effect at the next rising clock edge. A latch value written while the pin is an input does not drive the pad. Once the direction bit is then set, the pin drives that value at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 8 | Register index |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register, combinational |
| pad_in | input | 8 | Pad levels, asynchronous |
| pad_oe | output | 8 | Per-pin pad output enable |
| pad_out | output | 8 | Per-pin pad output value |

## Verification
The bench uses a six-pin bank at base 0xE0. First it sets all pins to each of the eight direction/mode/latch codes in turn. This separates input release, push-pull drive and both open-drain states. Next, pseudo-random mixed vectors give every pin its own combination, which exposes bit-lane swaps and cross-pin coupling. Fixed patterns cover the remaining cases:
- writes of all ones, which show the unimplemented lanes;
- writes to the read-only index and to the neighbouring out-of-bank indexes;
- a pad step sampled after one and after two clock edges, which pins down the synchroniser depth;
- a latch-then-direction sequence.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   localparam int BANK_W = 8;

   typedef enum logic [2:0] {
      SEL_DIR  = 3'd0,
      SEL_OUT  = 3'd1,
      SEL_LVL  = 3'd2,
      SEL_MODE = 3'd3,
      SEL_NONE = 3'd4
   } reg_sel_e;

   function automatic reg_sel_e decode_sel(input logic [7:0] addr,
                                           input logic [7:0] base);
      reg_sel_e s;
      if (addr[7:2] != base[7:2]) s = SEL_NONE;
      else begin
         case (addr[1:0])
            2'd0:    s = SEL_DIR;
            2'd1:    s = SEL_OUT;
            2'd2:    s = SEL_LVL;
            default: s = SEL_MODE;
         endcase
      end
      return s;
   endfunction

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);
   initial begin
      assert (STAGES >= 2 && STAGES <= 4)
         else $error("gpio_bank_sync: STAGES out of range");
   end

   logic [WIDTH-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= '0;
               else        chain[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
   import gpio_bank_pkg::*;
#(
   parameter logic [7:0] BASE_IDX  = 8'hF0,
   parameter int         PIN_COUNT = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [7:0]  reg_addr,
   input  logic        reg_wr,
   input  logic [7:0]  reg_wdata,
   input  logic [7:0]  lvl_sync,
   output logic [7:0]  reg_rdata,
   output logic [7:0]  dir_q,
   output logic [7:0]  out_q,
   output logic [7:0]  mode_q
);
   localparam logic [7:0] PIN_MASK = 8'((32'd1 << PIN_COUNT) - 32'd1);

   reg_sel_e sel;
   logic [7:0] lvl_view;

   assign sel = decode_sel(reg_addr, BASE_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '0;
         out_q  <= '0;
         mode_q <= '0;
      end else if (reg_wr) begin
         case (sel)
            SEL_DIR:  dir_q  <= reg_wdata & PIN_MASK;
            SEL_OUT:  out_q  <= reg_wdata & PIN_MASK;
            SEL_MODE: mode_q <= reg_wdata & PIN_MASK;
            default:  ;
         endcase
      end
   end

   generate
      for (genvar i = 0; i < BANK_W; i++) begin : g_view
         if (i < PIN_COUNT) begin : g_live
            assign lvl_view[i] = dir_q[i] ? out_q[i] : lvl_sync[i];
         end else begin : g_dead
            assign lvl_view[i] = 1'b0;
         end
      end
   endgenerate

   always_comb begin
      case (sel)
         SEL_DIR:  reg_rdata = dir_q;
         SEL_OUT:  reg_rdata = out_q;
         SEL_LVL:  reg_rdata = lvl_view;
         SEL_MODE: reg_rdata = mode_q;
         default:  reg_rdata = 8'h00;
      endcase
   end

   AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == BASE_IDX) |=> dir_q == ($past(reg_wdata) & PIN_MASK)); // R9

   AST_LVL_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == BASE_IDX + 8'd2)
         |=> ($stable(dir_q) && $stable(out_q) && $stable(mode_q))); // R7

   AST_FOREIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr[7:2] != BASE_IDX[7:2])
         |=> ($stable(dir_q) && $stable(out_q) && $stable(mode_q))); // R2
endmodule

// File: rtl/gpio_bank_drive.sv
module gpio_bank_drive
   import gpio_bank_pkg::*;
#(
   parameter int PIN_COUNT = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] dir_q,
   input  logic [7:0] out_q,
   input  logic [7:0] mode_q,
   output logic [7:0] pad_oe,
   output logic [7:0] pad_out
);
   generate
      for (genvar i = 0; i < BANK_W; i++) begin : g_pin
         if (i < PIN_COUNT) begin : g_live
            always_comb begin
               if (!dir_q[i]) begin
                  pad_oe[i]  = 1'b0;
                  pad_out[i] = 1'b0;
               end else if (mode_q[i]) begin
                  pad_oe[i]  = 1'b1;
                  pad_out[i] = out_q[i];
               end else begin
                  pad_oe[i]  = ~out_q[i];
                  pad_out[i] = 1'b0;
               end
            end
         end else begin : g_dead
            assign pad_oe[i]  = 1'b0;
            assign pad_out[i] = 1'b0;
         end
      end
   endgenerate

   AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_oe & ~mode_q & pad_out) == 8'h00)); // R5

   AST_PP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_oe & mode_q) == (dir_q & mode_q))); // R4
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
   parameter logic [7:0] BASE_IDX    = 8'hF0,
   parameter int         PIN_COUNT   = 8,
   parameter int         SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] reg_addr,
   input  logic       reg_wr,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   input  logic [7:0] pad_in,
   output logic [7:0] pad_oe,
   output logic [7:0] pad_out
);
   initial begin
      assert (PIN_COUNT >= 4 && PIN_COUNT <= 8)
         else $error("gpio_bank: PIN_COUNT must be 4..8");
      assert (BASE_IDX[1:0] == 2'b00)
         else $error("gpio_bank: BASE_IDX must be 4-aligned");
   end

   logic [7:0] lvl_sync;
   logic [7:0] dir_q, out_q, mode_q;

   gpio_bank_sync #(.WIDTH(8), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(lvl_sync));

   gpio_bank_regs #(.BASE_IDX(BASE_IDX), .PIN_COUNT(PIN_COUNT)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .lvl_sync(lvl_sync), .reg_rdata(reg_rdata),
      .dir_q(dir_q), .out_q(out_q), .mode_q(mode_q));

   gpio_bank_drive #(.PIN_COUNT(PIN_COUNT)) u_drive (
      .clk(clk), .rst_n(rst_n), .dir_q(dir_q), .out_q(out_q),
      .mode_q(mode_q), .pad_oe(pad_oe), .pad_out(pad_out));

   AST_INPUT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_oe & ~dir_q) == 8'h00)); // R3

   AST_DEAD_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr |=> ((dir_q | out_q | mode_q | pad_oe) >> PIN_COUNT) == 8'h00)); // R8
endmodule

// File: tb/gpio_bank_tb.sv
`timescale 1ns/1ps
module gpio_bank_tb_top;
   localparam logic [7:0] BASE = 8'hE0;
   localparam int         NPIN = 6;
   localparam logic [7:0] MASK = 8'h3F;

   logic clk = 0;
   logic rst_n = 0;
   logic [7:0] reg_addr = 0, reg_wdata = 0, pad_in = 0;
   logic reg_wr = 0;
   logic [7:0] reg_rdata, pad_oe, pad_out;
   int n_chk = 0, n_err = 0;
   logic [7:0] ed, eo, em, ep;
   logic [15:0] lfsr = 16'hACE1;

   always #2.5 clk = ~clk;

   gpio_bank #(.BASE_IDX(BASE), .PIN_COUNT(NPIN), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
      .pad_oe(pad_oe), .pad_out(pad_out));

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1;
      @(negedge clk);
      reg_wr = 0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      reg_addr = a;
      #0.5;
      d = reg_rdata;
   endtask

   function automatic logic [7:0] x_oe(input logic [7:0] d, o, m);
      return d & (m | ~o) & MASK;
   endfunction
   function automatic logic [7:0] x_out(input logic [7:0] d, o, m);
      return d & m & o & MASK;
   endfunction
   function automatic logic [7:0] x_lvl(input logic [7:0] d, o, p);
      return ((d & o) | (~d & p)) & MASK;
   endfunction

   task automatic check_all(input string tag);
      logic [7:0] v;
      chk({tag, " R3 R4 R5 oe"}, pad_oe, x_oe(ed, eo, em));
      chk({tag, " R4 R5 out"}, pad_out, x_out(ed, eo, em));
      rd(BASE, v);         chk({tag, " R2 dir"}, v, ed & MASK);
      rd(BASE + 8'd1, v);  chk({tag, " R2 latch"}, v, eo & MASK);
      rd(BASE + 8'd2, v);  chk({tag, " R6 level"}, v, x_lvl(ed, eo, ep));
      rd(BASE + 8'd3, v);  chk({tag, " R2 mode"}, v, em & MASK);
   endtask

   task automatic step_lfsr();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      chk("R1 oe in reset", pad_oe, 8'h00);
      rst_n = 1;
      @(negedge clk);
      ed = 0; eo = 0; em = 0; ep = 0;
      check_all("R1 after reset");

      // uniform codes: bit0 dir, bit1 mode, bit2 latch
      for (int c = 0; c < 8; c++) begin
         ed = c[0] ? 8'hFF : 8'h00;
         em = c[1] ? 8'hFF : 8'h00;
         eo = c[2] ? 8'hFF : 8'h00;
         wr(BASE + 8'd1, eo);
         wr(BASE + 8'd3, em);
         wr(BASE, ed);
         check_all($sformatf("uniform code %0d R8", c));
      end

      // mixed per-pin vectors
      for (int k = 0; k < 48; k++) begin
         step_lfsr(); ed = lfsr[7:0];
         step_lfsr(); eo = lfsr[7:0];
         step_lfsr(); em = lfsr[7:0];
         step_lfsr(); ep = lfsr[7:0];
         @(negedge clk); pad_in = ep;
         wr(BASE + 8'd1, eo);
         wr(BASE + 8'd3, em);
         wr(BASE, ed);
         check_all($sformatf("mixed %0d", k));
      end

      // R7: write to read-only level register
      wr(BASE + 8'd2, ~eo);
      check_all("R7 level write ignored");

      // R2: neighbouring indexes outside the bank
      wr(BASE - 8'd1, 8'h5A);
      wr(BASE + 8'd4, 8'hA5);
      check_all("R2 foreign writes");
      rd(BASE + 8'd4, v);  chk("R2 foreign read +4", v, 8'h00);
      rd(BASE - 8'd1, v);  chk("R2 foreign read -1", v, 8'h00);

      // R6: synchroniser latency
      ed = 0; wr(BASE, 8'h00);
      @(negedge clk); pad_in = 8'h00;
      repeat (3) @(negedge clk);
      pad_in = 8'h15; reg_addr = BASE + 8'd2;
      #0.5 chk("R6 level before edge", reg_rdata, 8'h00);
      @(negedge clk);
      #0.5 chk("R6 level after 1 edge", reg_rdata, 8'h00);
      @(negedge clk);
      #0.5 chk("R6 level after 2 edges", reg_rdata, 8'h15);

      // R9: latch first, then direction
      wr(BASE + 8'd3, 8'hFF);
      wr(BASE + 8'd1, 8'h2D);
      chk("R9 latch alone no drive", pad_oe, 8'h00);
      @(negedge clk);
      reg_addr = BASE; reg_wdata = 8'hFF; reg_wr = 1;
      #0.5 chk("R9 before edge", pad_oe, 8'h00);
      @(negedge clk); reg_wr = 0;
      chk("R9 oe after dir", pad_oe, MASK);
      chk("R9 value after dir", pad_out, 8'h2D);

      // R8: all-ones into every register
      wr(BASE, 8'hFF); wr(BASE + 8'd1, 8'hFF); wr(BASE + 8'd3, 8'h00);
      ed = 8'hFF; eo = 8'hFF; em = 8'h00; ep = 8'h15;
      check_all("R8 all ones open-drain");

      // R1: reset mid-run clears state
      @(negedge clk); rst_n = 0;
      @(negedge clk); rst_n = 1;
      @(negedge clk);
      ed = 0; eo = 0; em = 0; pad_in = 8'h00;
      repeat (3) @(negedge clk);
      ep = 0;
      check_all("R1 re-reset");

      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule